// File: doc/BRIEF.md
# Predicated Store-Multiple Sequencer

This block carries out one store-multiple operation. It writes a run of consecutive registers to memory, one word per beat. Each word goes out at the current address, and then the address steps up by one word (increment-after). The operation runs only if a condition holds. The condition is tested against one of four independent flag sets, and the operation names which set to use. When the condition fails, or the register count is zero, the operation finishes at once with no side effects.

When write-back is requested, the final address is sent to the base register. This happens only after every store has been accepted. A stack push is the same operation with the stack-pointer register as the base and write-back enabled. An abort input stops the sequence between beats and suppresses the write-back, so the operation can be issued again from the start. Data words come through a combinational register-file read port. The sequencer drives the read index and forwards the read data unchanged as the memory write data.

Top module: `stm_sequencer`

## Requirements
- R1: The condition is tested against the flag set picked by `fset_sel`. Set k occupies `flag_sets[4k+3:4k]`, laid out as N (bit 3), Z (bit 2), C (bit 1), V (bit 0). The condition codes are:
  - 0 always
  - 1 Z set
  - 2 Z clear
  - 3 GE (N equals V)
  - 4 LT (N differs from V)
  - 5 C set
  - 6 C clear
  - 7 N set
  - 8 N clear
  - 9 GT (Z clear and N equals V)
  - 10 LE (Z set or N differs from V)
  - any other code: never
- R2: When the condition is false, there are no memory beats and no write-back, and `done` is high in the cycle that directly follows the accepted `start`.
- R3: A register count of zero behaves the same as a false condition: no beats, no write-back, and `done` one cycle after `start`.
- R4: Beat i reads register index (`first_reg` + i) modulo 64 on `rf_raddr`. It carries the value returned on `rf_rdata` as `mem_wdata`. The beats go out in ascending order.
- R5: Beat i is written at `base_addr` + 4·i, modulo 2^32.
- R6: While `mem_valid` is high and `mem_ready` is low, the beat is held: `mem_valid`, `mem_addr` and `rf_raddr` are unchanged in the next cycle unless `abort` is raised. At most one beat completes per cycle.
- R7: With `wback` set, `wb_en` is high for exactly the cycle in which `done` is high after the last beat. In that cycle `wb_reg` = `base_reg` and `wb_addr` = `base_addr` + 4·count. With `wback` clear, `wb_en` stays low.
- R8: `done` is a single-cycle pulse. After a completed run it rises in the cycle following the handshake of the final beat.
- R9: While a run is in progress, `abort` forces `mem_valid` low in the same cycle. No further beats complete. `done` follows in the next cycle with `wb_en` low.
- R10: `start` is ignored unless the sequencer is idle. A second `start` during a run changes neither the beats nor the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the fields below (idle only) |
| first_reg | input | 6 | Index of the first register stored |
| reg_count | input | 7 | Number of registers stored |
| base_reg | input | 6 | Index of the base register for write-back |
| base_addr | input | 32 | Current value of the base register |
| fset_sel | input | 2 | Which flag set the condition is tested against |
| cond_code | input | 4 | Condition code |
| wback | input | 1 | Write the final address back to the base register |
| flag_sets | input | 16 | Four flag sets, four bits each |
| abort | input | 1 | Stop the run and suppress write-back |
| rf_raddr | output | 6 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| mem_valid | output | 1 | A memory write beat is offered |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Data of the beat |
| mem_ready | input | 1 | Memory accepts the beat at this edge |
| wb_en | output | 1 | Base write-back strobe |
| wb_reg | output | 6 | Register index for the write-back |
| wb_addr | output | 32 | Final address written back |
| done | output | 1 | Operation finished (one-cycle pulse) |

## Verification
A skipped operation (false condition or zero count) owes `done` in the first cycle after `start`. A running operation offers its first beat in that same cycle. The bench changes its inputs on the falling edge and reads the outputs one time unit later. A beat is counted only when `mem_valid` and `mem_ready` are both high in that sample, and `done` with the write-back is then required in the very next sample. An abort is required to drop `mem_valid` within the sample in which it is raised, with `done` and no write-back due one sample later. Each of these distances is checked as an exact cycle count, under ready patterns that stall every second or third cycle.

// File: rtl/stm_pkg.sv
package stm_pkg;

    localparam int FLAG_W = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [3:0] {
        CC_AL = 4'd0,
        CC_EQ = 4'd1,
        CC_NE = 4'd2,
        CC_GE = 4'd3,
        CC_LT = 4'd4,
        CC_CS = 4'd5,
        CC_CC = 4'd6,
        CC_MI = 4'd7,
        CC_PL = 4'd8,
        CC_GT = 4'd9,
        CC_LE = 4'd10
    } cond_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_DONE  = 2'd2
    } state_e;

    function automatic logic cond_holds(input flags_t f, input logic [3:0] c);
        logic r;
        case (c)
            CC_AL:   r = 1'b1;
            CC_EQ:   r = f.z;
            CC_NE:   r = !f.z;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_CS:   r = f.c;
            CC_CC:   r = !f.c;
            CC_MI:   r = f.n;
            CC_PL:   r = !f.n;
            CC_GT:   r = !f.z && (f.n == f.v);
            CC_LE:   r = f.z || (f.n != f.v);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/stm_predicate.sv
module stm_predicate
    import stm_pkg::*;
#(
    parameter int NUM_FSETS = 4,
    localparam int SEL_W = (NUM_FSETS > 1) ? $clog2(NUM_FSETS) : 1
) (
    input  logic [NUM_FSETS*FLAG_W-1:0] flag_sets,
    input  logic [SEL_W-1:0]            fset_sel,
    input  logic [3:0]                  cond_code,
    output logic                        take
);

    flags_t fset [NUM_FSETS];

    for (genvar k = 0; k < NUM_FSETS; k++) begin : g_unpack
        assign fset[k] = flags_t'(flag_sets[k*FLAG_W +: FLAG_W]);
    end

    flags_t chosen;
    always_comb begin
        chosen = '0;
        for (int k = 0; k < NUM_FSETS; k++) begin
            if (fset_sel == SEL_W'(k)) chosen = fset[k];
        end
    end

    assign take = cond_holds(chosen, cond_code);

endmodule

// File: rtl/stm_beat_counter.sv
module stm_beat_counter #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 6,
    parameter int CNT_W      = 7,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  first,
    input  logic [CNT_W-1:0]  count,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr      <= '0;
            idx       <= '0;
            remaining <= '0;
        end else if (load) begin
            addr      <= base;
            idx       <= first;
            remaining <= count;
        end else if (advance) begin
            addr      <= addr + STEP;
            idx       <= idx + 1'b1;
            remaining <= remaining - 1'b1;
        end
    end

    assign last = (remaining == CNT_W'(1));

    AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        advance |=> (idx == $past(idx) + 1'b1)); // R4

endmodule

// File: rtl/stm_ctrl.sv
module stm_ctrl
    import stm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic take,
    input  logic count_zero,
    input  logic wback_req,
    input  logic beat_fire,
    input  logic last_beat,
    input  logic abort,
    output logic capture,
    output logic in_store,
    output logic done,
    output logic wb_fire
);

    state_e st;
    logic   wb_pending;

    assign capture  = (st == ST_IDLE) && start;
    assign in_store = (st == ST_STORE);
    assign done     = (st == ST_DONE);
    assign wb_fire  = done && wb_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            wb_pending <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (take && !count_zero) begin
                            st         <= ST_STORE;
                            wb_pending <= wback_req;
                        end else begin
                            st         <= ST_DONE;
                            wb_pending <= 1'b0;
                        end
                    end
                end
                ST_STORE: begin
                    if (abort) begin
                        st         <= ST_DONE;
                        wb_pending <= 1'b0;
                    end else if (beat_fire && last_beat) begin
                        st <= ST_DONE;
                    end
                end
                default: begin
                    st         <= ST_IDLE;
                    wb_pending <= 1'b0;
                end
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_SKIP_FINISH: assert property (@(posedge clk) disable iff (rst)
        (capture && (!take || count_zero)) |=> (done && !wb_fire)); // R2

    AST_ABORT_FINISH: assert property (@(posedge clk) disable iff (rst)
        (in_store && abort) |=> (done && !wb_fire)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (in_store && start && !abort && !(beat_fire && last_beat)) |=> in_store); // R10

endmodule

// File: rtl/stm_sequencer.sv
module stm_sequencer
    import stm_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 6,
    parameter int NUM_FSETS = 4,
    localparam int CNT_W      = REG_IDX_W + 1,
    localparam int SEL_W      = (NUM_FSETS > 1) ? $clog2(NUM_FSETS) : 1,
    localparam int STEP_BYTES = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [REG_IDX_W-1:0]        first_reg,
    input  logic [CNT_W-1:0]            reg_count,
    input  logic [REG_IDX_W-1:0]        base_reg,
    input  logic [ADDR_W-1:0]           base_addr,
    input  logic [SEL_W-1:0]            fset_sel,
    input  logic [3:0]                  cond_code,
    input  logic                        wback,
    input  logic [NUM_FSETS*FLAG_W-1:0] flag_sets,
    input  logic                        abort,
    output logic [REG_IDX_W-1:0]        rf_raddr,
    input  logic [DATA_W-1:0]           rf_rdata,
    output logic                        mem_valid,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic                        mem_ready,
    output logic                        wb_en,
    output logic [REG_IDX_W-1:0]        wb_reg,
    output logic [ADDR_W-1:0]           wb_addr,
    output logic                        done
);

    logic take, capture, in_store, beat_fire, last_beat;
    logic [ADDR_W-1:0] cur_addr;

    stm_predicate #(.NUM_FSETS(NUM_FSETS)) u_pred (
        .flag_sets (flag_sets),
        .fset_sel  (fset_sel),
        .cond_code (cond_code),
        .take      (take)
    );

    stm_beat_counter #(
        .ADDR_W(ADDR_W), .IDX_W(REG_IDX_W), .CNT_W(CNT_W), .STEP_BYTES(STEP_BYTES)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (capture),
        .base    (base_addr),
        .first   (first_reg),
        .count   (reg_count),
        .advance (beat_fire),
        .addr    (cur_addr),
        .idx     (rf_raddr),
        .last    (last_beat)
    );

    stm_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .take       (take),
        .count_zero (reg_count == '0),
        .wback_req  (wback),
        .beat_fire  (beat_fire),
        .last_beat  (last_beat),
        .abort      (abort),
        .capture    (capture),
        .in_store   (in_store),
        .done       (done),
        .wb_fire    (wb_en)
    );

    always_ff @(posedge clk) begin
        if (rst)          wb_reg <= '0;
        else if (capture) wb_reg <= base_reg;
    end

    assign mem_valid = in_store && !abort;
    assign beat_fire = mem_valid && mem_ready;
    assign mem_addr  = cur_addr;
    assign mem_wdata = rf_rdata;
    assign wb_addr   = cur_addr;

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> ((mem_valid || abort) && $stable(mem_addr) && $stable(rf_raddr))); // R6

    AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && !last_beat) |=> (mem_addr == $past(mem_addr) + ADDR_W'(STEP_BYTES))); // R5

    AST_WB_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done); // R7

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        abort |-> !mem_valid); // R9

endmodule

// File: tb/test_stm_sequencer.sv
module test_stm_sequencer;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [5:0]  first_reg;
    logic [6:0]  reg_count;
    logic [5:0]  base_reg;
    logic [31:0] base_addr;
    logic [1:0]  fset_sel;
    logic [3:0]  cond_code;
    logic        wback;
    logic [15:0] flag_sets;
    logic        abort;
    logic [5:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        mem_valid;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready;
    logic        wb_en;
    logic [5:0]  wb_reg;
    logic [31:0] wb_addr;
    logic        done;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rf_val(input logic [5:0] i);
        return 32'hC0DE_0000 + 32'(i) * 32'h0000_0101;
    endfunction

    assign rf_rdata = rf_val(rf_raddr);

    stm_sequencer i_stm_sequencer (
        .clk(clk), .rst(rst), .start(start), .first_reg(first_reg), .reg_count(reg_count),
        .base_reg(base_reg), .base_addr(base_addr), .fset_sel(fset_sel), .cond_code(cond_code),
        .wback(wback), .flag_sets(flag_sets), .abort(abort), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .wb_en(wb_en), .wb_reg(wb_reg), .wb_addr(wb_addr), .done(done)
    );

    typedef struct packed {
        logic [5:0]  first;
        logic [6:0]  count;
        logic [5:0]  breg;
        logic [1:0]  fset;
        logic [3:0]  cond;
        logic        wb;
        logic [31:0] base;
        logic [15:0] flags;
        logic [1:0]  stall;
        logic        exec;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'd10, 7'd10, 6'd62, 2'd2, 4'd1,  1'b1, 32'h0000_1000, 16'h0400, 2'd0, 1'b1},
        '{6'd10, 7'd10, 6'd62, 2'd2, 4'd1,  1'b1, 32'h0000_1000, 16'h0000, 2'd0, 1'b0},
        '{6'd0,  7'd3,  6'd5,  2'd1, 4'd3,  1'b0, 32'h0000_2000, 16'h0090, 2'd1, 1'b1},
        '{6'd0,  7'd3,  6'd5,  2'd1, 4'd3,  1'b1, 32'h0000_2000, 16'h0080, 2'd1, 1'b0},
        '{6'd63, 7'd1,  6'd7,  2'd3, 4'd0,  1'b1, 32'hFFFF_FFFC, 16'h0000, 2'd2, 1'b1},
        '{6'd4,  7'd2,  6'd1,  2'd0, 4'd1,  1'b1, 32'h0000_0400, 16'h0040, 2'd0, 1'b0},
        '{6'd62, 7'd5,  6'd9,  2'd0, 4'd5,  1'b1, 32'h0000_0100, 16'h0002, 2'd1, 1'b1},
        '{6'd1,  7'd4,  6'd3,  2'd1, 4'd15, 1'b1, 32'h0000_0300, 16'hFFFF, 2'd0, 1'b0},
        '{6'd20, 7'd0,  6'd2,  2'd0, 4'd0,  1'b1, 32'h0000_0500, 16'h0000, 2'd0, 1'b1}
    };

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // abort_at: beat count at which abort is raised (-1: none); poke: second start mid-run
    task automatic run_op(input vec_t v, input int abort_at, input bit poke, input string tag);
        int nb = 0;
        int cyc = 0;
        int last_cyc = -1;
        int abort_cyc = -1;
        bit fin = 0;
        int exp_beats = v.exec ? int'(v.count) : 0;
        bit exp_wb;
        @(negedge clk);
        first_reg = v.first; reg_count = v.count; base_reg = v.breg; base_addr = v.base;
        fset_sel = v.fset; cond_code = v.cond; wback = v.wb; flag_sets = v.flags;
        start = 1'b1; abort = 1'b0; mem_ready = 1'b0;
        while (!fin && cyc < 400) begin
            @(negedge clk);
            cyc++;
            start = poke && (cyc == 2);
            if (poke && cyc == 2) begin
                first_reg = 6'd40; reg_count = 7'd2; base_addr = 32'h0000_9000; wback = 1'b0;
            end
            abort = (abort_at >= 0) && (nb == abort_at) && (abort_cyc < 0);
            if (abort) abort_cyc = cyc;
            mem_ready = (v.stall == 2'd0) || ((cyc % (int'(v.stall) + 1)) == int'(v.stall));
            #1;
            if (abort) check(!mem_valid, "R9", {tag, " valid during abort"}, 32'(mem_valid), 0);
            if (mem_valid && mem_ready) begin
                check(rf_raddr == 6'(v.first + 6'(nb)), "R4", {tag, " read index"},
                      32'(rf_raddr), 32'(6'(v.first + 6'(nb))));
                check(mem_wdata == rf_val(6'(v.first + 6'(nb))), "R4", {tag, " write data"},
                      mem_wdata, rf_val(6'(v.first + 6'(nb))));
                check(mem_addr == v.base + 32'(4 * nb), "R5", {tag, " beat address"},
                      mem_addr, v.base + 32'(4 * nb));
                nb++;
                last_cyc = cyc;
            end
            if (done) begin
                fin = 1;
                if (abort_cyc >= 0)
                    check(cyc == abort_cyc + 1, "R9", {tag, " done after abort"}, 32'(cyc), 32'(abort_cyc + 1));
                else if (exp_beats == 0)
                    check(cyc == 1, v.count == 0 ? "R3" : "R2", {tag, " skip latency"}, 32'(cyc), 1);
                else
                    check(cyc == last_cyc + 1, "R8", {tag, " done latency"}, 32'(cyc), 32'(last_cyc + 1));
                exp_wb = v.wb && (exp_beats > 0) && (abort_cyc < 0);
                check(wb_en == exp_wb, "R7", {tag, " wb_en"}, 32'(wb_en), 32'(exp_wb));
                if (exp_wb) begin
                    check(wb_addr == v.base + 32'(4 * int'(v.count)), "R7", {tag, " wb_addr"},
                          wb_addr, v.base + 32'(4 * int'(v.count)));
                    check(wb_reg == v.breg, "R7", {tag, " wb_reg"}, 32'(wb_reg), 32'(v.breg));
                end
            end
        end
        check(fin, "R8", {tag, " done seen"}, 32'(fin), 1);
        if (abort_at >= 0)
            check(nb == abort_at, "R9", {tag, " beats before abort"}, 32'(nb), 32'(abort_at));
        else
            check(nb == exp_beats, poke ? "R10" : (v.exec ? "R1" : "R2"), {tag, " beat count"},
                  32'(nb), 32'(exp_beats));
        @(negedge clk);
        start = 1'b0; abort = 1'b0; mem_ready = 1'b1;
        #1;
        check(!done && !wb_en && !mem_valid, "R8", {tag, " idle after done"},
              32'({done, wb_en, mem_valid}), 0);
    endtask

    initial begin
        rst = 1'b1; start = 0; first_reg = 0; reg_count = 0; base_reg = 0; base_addr = 0;
        fset_sel = 0; cond_code = 0; wback = 0; flag_sets = 0; abort = 0; mem_ready = 0;
        repeat (3) @(negedge clk);
        #1;
        check(!mem_valid && !done && !wb_en, "R8", "reset outputs", 32'({mem_valid, done, wb_en}), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_op(VECS[i], -1, 1'b0, $sformatf("vec%0d", i));

        // R9: abort after three beats of an eight-register push with write-back
        run_op('{6'd8, 7'd8, 6'd62, 2'd0, 4'd0, 1'b1, 32'h0000_3000, 16'h0000, 2'd1, 1'b1},
               3, 1'b0, "abort");
        // R10: second start during a run is ignored
        run_op('{6'd30, 7'd6, 6'd11, 2'd3, 4'd8, 1'b1, 32'h0000_4000, 16'h0000, 2'd2, 1'b1},
               -1, 1'b1, "poke");
        // R6: heavy stalls on a long run, LE condition on set 2
        run_op('{6'd0, 7'd64, 6'd62, 2'd2, 4'd10, 1'b1, 32'h0001_0000, 16'h0800, 2'd2, 1'b1},
               -1, 1'b0, "long");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule